// File: doc/BRIEF.md
# Aperture Page Remapping Table

This block maps a fixed window of device addresses onto physical memory in 4 KiB pages. It keeps one 32-bit entry per page of the window. Software never addresses the entries directly. It first writes a full device address into a pointer register, and then reads or writes a data register that stands for the entry selected by that pointer. A config register turns translation on and off. Reading it back returns its present value, so software can use that read to make sure its earlier register writes have landed.

Lookups flow through a valid/ready stream. A requester offers a device address on the lookup side. One cycle after the block accepts it, the block presents either the remapped physical address or a fault flag. The page offset (the low 12 bits) is carried through unchanged. The physical page base comes from bits 30:12 of the selected entry, and bit 31 of that entry marks it as valid. The output holds one result. When the consumer stalls, the block lowers its lookup ready, so back-pressure reaches the requester with no extra buffering.

Top module: `aperture_remap`

## Requirements
- R1: After reset, translation is disabled, the config register reads 0, every entry reads 0, res_valid is low and lk_ready is high.
- R2: A write to offset 0x0 sets the enable from reg_wdata bit 0. A read of offset 0x0 returns 31 zero bits above the enable bit.
- R3: A write to offset 0x4 stores all 32 bits of reg_wdata as the entry pointer. A read of offset 0x4 returns it unchanged.
- R4: When the pointer lies in the window, a write to offset 0x8 stores reg_wdata into entry (pointer − AP_BASE) >> 12, and a read of 0x8 returns that entry. Read data appears on reg_rdata in the cycle after reg_rd is sampled, and reads of other offsets return 0.
- R5: When the pointer lies outside the window, a write to offset 0x8 changes no entry, including the entry its truncated index bits would name. A read of 0x8 returns 0.
- R6: A lookup that hits returns res_fault = 0 and res_addr = {1'b0, entry[30:12], lk_addr[11:0]}.
- R7: While translation is disabled, every lookup returns res_fault = 1.
- R8: An address is inside the window only if AP_BASE <= lk_addr < AP_BASE + AP_PAGES*4096. A lookup outside the window faults. Every faulting result carries res_addr = 0.
- R9: A lookup whose selected entry has bit 31 clear faults. This includes an entry written as all zeros, which is how a page is unmapped.
- R10: lk_ready is high exactly when the output slot is empty or res_ready is high. An accepted lookup gives res_valid in the next cycle. While res_valid is high and res_ready is low, res_addr and res_fault hold steady.
- R11: An entry written through offset 0x8 is used by a lookup accepted in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_off | input | 4 | Register byte offset (0x0 config, 0x4 pointer, 0x8 entry data) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_rd |
| lk_valid | input | 1 | Lookup address offered |
| lk_ready | output | 1 | Lookup accepted when high with lk_valid |
| lk_addr | input | 32 | Device address to translate |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_addr | output | 32 | Physical address, 0 on a fault |
| res_fault | output | 1 | Lookup faulted |

## Verification
The assertions assume that a requester holds lk_valid and lk_addr until the lookup is accepted. They also assume at most one register strobe per cycle, and they let res_ready toggle freely. The bench drives every input on the falling edge. It raises only one of reg_wr, reg_rd or lk_valid at a time, and it keeps a lookup offered until it sees lk_ready high. While a lookup burst runs, a separate process toggles res_ready in an irregular pattern, so that stalls fall both on freshly loaded results and on results that have already waited.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int VALID_BIT  = 31;

  localparam logic [3:0] OFF_CFG   = 4'h0;
  localparam logic [3:0] OFF_PTR   = 4'h4;
  localparam logic [3:0] OFF_EDATA = 4'h8;

  // True when a lies in [base, base + pages * page size)
  function automatic logic in_window(input logic [31:0] a,
                                     input logic [31:0] base,
                                     input int unsigned pages);
    logic [32:0] lo, hi, av;
    lo = {1'b0, base};
    hi = lo + ({1'b0, 32'(pages)} << PAGE_SHIFT);
    av = {1'b0, a};
    return (av >= lo) && (av < hi);
  endfunction

  function automatic logic [31:0] page_index(input logic [31:0] a,
                                             input logic [31:0] base);
    return (a - base) >> PAGE_SHIFT;
  endfunction

  function automatic logic [31:0] phys_of(input logic [31:0] entry,
                                          input logic [31:0] a);
    return {1'b0, entry[30:PAGE_SHIFT], a[PAGE_SHIFT-1:0]};
  endfunction
endpackage

// File: rtl/remap_regs.sv
module remap_regs
  import remap_pkg::*;
#(
  parameter logic [31:0] AP_BASE  = 32'h4000_0000,
  parameter int unsigned AP_PAGES = 16,
  parameter int          IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [3:0]       reg_off,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             cfg_en,
  output logic             ent_we,
  output logic [IDX_W-1:0] ent_idx,
  input  logic [31:0]      ent_rdata
);
  logic [31:0] ptr_q;
  logic        ptr_ok;
  logic [31:0] rd_mux;

  assign ptr_ok  = in_window(ptr_q, AP_BASE, AP_PAGES);
  assign ent_idx = IDX_W'(page_index(ptr_q, AP_BASE));
  assign ent_we  = reg_wr && (reg_off == OFF_EDATA) && ptr_ok;

  always_comb begin
    case (reg_off)
      OFF_CFG:   rd_mux = {31'b0, cfg_en};
      OFF_PTR:   rd_mux = ptr_q;
      OFF_EDATA: rd_mux = ptr_ok ? ent_rdata : 32'b0;
      default:   rd_mux = 32'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en    <= 1'b0;
      ptr_q     <= 32'b0;
      reg_rdata <= 32'b0;
    end else begin
      if (reg_wr && reg_off == OFF_CFG) cfg_en <= reg_wdata[0];
      if (reg_wr && reg_off == OFF_PTR) ptr_q  <= reg_wdata;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/remap_table.sv
module remap_table #(
  parameter int unsigned AP_PAGES = 16,
  parameter int          IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [31:0]      wdata,
  input  logic [IDX_W-1:0] ridx_a,
  output logic [31:0]      rdata_a,
  input  logic [IDX_W-1:0] ridx_b,
  output logic [31:0]      rdata_b
);
  logic [31:0] ent_q [AP_PAGES];

  for (genvar g = 0; g < int'(AP_PAGES); g++) begin : g_ent
    logic [31:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            q <= 32'b0;
      else if (we && widx == IDX_W'(g))      q <= wdata;
    end
    assign ent_q[g] = q;
  end

  assign rdata_a = (32'(ridx_a) < AP_PAGES) ? ent_q[ridx_a] : 32'b0;
  assign rdata_b = (32'(ridx_b) < AP_PAGES) ? ent_q[ridx_b] : 32'b0;
endmodule

// File: rtl/remap_xlate.sv
module remap_xlate
  import remap_pkg::*;
#(
  parameter logic [31:0] AP_BASE  = 32'h4000_0000,
  parameter int unsigned AP_PAGES = 16,
  parameter int          IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xlate_en,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [31:0]      lk_addr,
  output logic [IDX_W-1:0] lk_idx,
  input  logic [31:0]      lk_entry,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [31:0]      res_addr,
  output logic             res_fault
);
  logic in_win, hit;

  assign in_win   = in_window(lk_addr, AP_BASE, AP_PAGES);
  assign lk_idx   = IDX_W'(page_index(lk_addr, AP_BASE));
  assign hit      = in_win && xlate_en && lk_entry[VALID_BIT];
  assign lk_ready = !res_valid || res_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_addr  <= 32'b0;
      res_fault <= 1'b0;
    end else if (lk_ready) begin
      res_valid <= lk_valid;
      if (lk_valid) begin
        res_fault <= !hit;
        res_addr  <= hit ? phys_of(lk_entry, lk_addr) : 32'b0;
      end
    end
  end
endmodule

// File: rtl/aperture_remap.sv
module aperture_remap #(
  parameter logic [31:0] AP_BASE  = 32'h4000_0000,
  parameter int unsigned AP_PAGES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_off,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        lk_valid,
  output logic        lk_ready,
  input  logic [31:0] lk_addr,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [31:0] res_addr,
  output logic        res_fault
);
  localparam int IDX_W = (AP_PAGES > 1) ? $clog2(AP_PAGES) : 1;

  logic             cfg_en;
  logic             ent_we;
  logic [IDX_W-1:0] ent_idx, lk_idx;
  logic [31:0]      ent_rdata, lk_entry;

  remap_regs #(.AP_BASE(AP_BASE), .AP_PAGES(AP_PAGES), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cfg_en(cfg_en), .ent_we(ent_we), .ent_idx(ent_idx), .ent_rdata(ent_rdata)
  );

  remap_table #(.AP_PAGES(AP_PAGES), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n), .we(ent_we), .widx(ent_idx), .wdata(reg_wdata),
    .ridx_a(ent_idx), .rdata_a(ent_rdata), .ridx_b(lk_idx), .rdata_b(lk_entry)
  );

  remap_xlate #(.AP_BASE(AP_BASE), .AP_PAGES(AP_PAGES), .IDX_W(IDX_W)) u_xlate (
    .clk(clk), .rst_n(rst_n), .xlate_en(cfg_en), .lk_valid(lk_valid),
    .lk_ready(lk_ready), .lk_addr(lk_addr), .lk_idx(lk_idx), .lk_entry(lk_entry),
    .res_valid(res_valid), .res_ready(res_ready), .res_addr(res_addr),
    .res_fault(res_fault)
  );
endmodule

// File: rtl/remap_checker.sv
module remap_checker
  import remap_pkg::*;
#(
  parameter logic [31:0] AP_BASE  = 32'h4000_0000,
  parameter int unsigned AP_PAGES = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_en,
  input logic        lk_valid,
  input logic        lk_ready,
  input logic [31:0] lk_addr,
  input logic        res_valid,
  input logic        res_ready,
  input logic [31:0] res_addr,
  input logic        res_fault
);
  logic take;
  assign take = lk_valid && lk_ready;

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_addr) && $stable(res_fault)));

  assert_accept_gives_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> res_valid);

  assert_empty_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> lk_ready);

  assert_outside_faults_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_window(lk_addr, AP_BASE, AP_PAGES)) |=> (res_valid && res_fault));

  assert_fault_addr_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault) |-> (res_addr == 32'b0));

  assert_disabled_faults_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cfg_en) |=> res_fault);

  assert_offset_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (res_fault || res_addr[11:0] == $past(lk_addr[11:0])));
endmodule

bind aperture_remap remap_checker #(.AP_BASE(AP_BASE), .AP_PAGES(AP_PAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .lk_valid(lk_valid),
  .lk_ready(lk_ready), .lk_addr(lk_addr), .res_valid(res_valid),
  .res_ready(res_ready), .res_addr(res_addr), .res_fault(res_fault)
);

// File: tb/aperture_remap_bench.sv
module aperture_remap_bench;
  localparam logic [31:0] BASE  = 32'h4000_0000;
  localparam int unsigned PAGES = 16;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [3:0] reg_off = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic lk_valid = 0, lk_ready;
  logic [31:0] lk_addr = 0;
  logic res_valid, res_ready = 1, res_fault;
  logic [31:0] res_addr;

  aperture_remap #(.AP_BASE(BASE), .AP_PAGES(PAGES)) u_aperture_remap (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  typedef struct { logic f; logic [31:0] a; string tag; } exp_t;
  exp_t sbq[$];

  // Bench-side model
  logic [31:0] sh [PAGES];
  logic [31:0] m_ptr = 0;
  logic        m_en = 0;
  logic        bp_on = 0;
  int          cyc = 0;

  function automatic logic inwin(input logic [31:0] a);
    longint av = longint'(a), lo = longint'(BASE);
    return av >= lo && av < lo + longint'(PAGES) * 4096;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] off, input logic [31:0] d);
    @(negedge clk);
    lk_valid = 0; reg_rd = 0; reg_wr = 1; reg_off = off; reg_wdata = d;
    if (off == 4'h0) m_en = d[0];
    if (off == 4'h4) m_ptr = d;
    if (off == 4'h8 && inwin(m_ptr)) sh[(m_ptr - BASE) >> 12] = d;
    @(posedge clk);
  endtask

  task automatic reg_read(input logic [3:0] off, input logic [31:0] exp, input string tag);
    @(negedge clk);
    lk_valid = 0; reg_wr = 0; reg_rd = 1; reg_off = off;
    @(posedge clk);
    @(negedge clk);
    reg_rd = 0;
    chk(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  task automatic lookup(input logic [31:0] a, input string tag);
    exp_t e;
    logic [31:0] ent;
    ent = inwin(a) ? sh[(a - BASE) >> 12] : 32'b0;
    e.f = !(inwin(a) && m_en && ent[31]);
    e.a = e.f ? 32'b0 : ((ent & 32'h7FFF_F000) | (a & 32'h0000_0FFF));
    e.tag = tag;
    @(negedge clk);
    reg_wr = 0; reg_rd = 0; lk_valid = 1; lk_addr = a;
    forever begin
      #1;
      if (lk_ready) break;
      @(negedge clk);
    end
    sbq.push_back(e);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    lk_valid = 0; reg_wr = 0; reg_rd = 0;
  endtask

  // Back-pressure driver
  initial forever begin
    @(negedge clk);
    cyc++;
    res_ready = bp_on ? (cyc % 3 == 0 || cyc % 7 == 0) : 1'b1;
  end

  // Monitor: scoreboard compare and hold check
  logic        held = 0;
  logic [31:0] held_a;
  logic        held_f;
  initial forever begin
    @(negedge clk);
    #2;
    if (held) begin
      chk(res_valid === 1'b1 && res_addr === held_a && res_fault === held_f,
          "R10 stall hold", res_addr, held_a);
    end
    held = 0;
    if (res_valid && !res_ready) begin
      held = 1; held_a = res_addr; held_f = res_fault;
    end
    if (res_valid && res_ready) begin
      if (sbq.size() == 0) chk(1'b0, "R10 unexpected result", res_addr, 32'b0);
      else begin
        exp_t e;
        e = sbq.pop_front();
        chk(res_fault === e.f, {e.tag, " fault"}, {31'b0, res_fault}, {31'b0, e.f});
        chk(res_addr === e.a, {e.tag, " addr"}, res_addr, e.a);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < int'(PAGES); i++) sh[i] = 32'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    chk(res_valid === 1'b0, "R1 res_valid", {31'b0, res_valid}, 32'b0);
    chk(lk_ready === 1'b1, "R1 lk_ready", {31'b0, lk_ready}, 32'b1);
    reg_read(4'h0, 32'b0, "R1 config");
    reg_write(4'h4, BASE + 32'h5000);
    reg_read(4'h8, 32'b0, "R1 entry");

    // Disabled translation
    reg_write(4'h4, BASE);
    reg_write(4'h8, 32'h8004_5000);
    lookup(BASE + 32'h123, "R7 disabled");
    reg_write(4'h0, 32'h1);
    reg_read(4'h0, 32'h1, "R2 enable readback");
    reg_read(4'hC, 32'h0, "R4 unused offset");
    lookup(BASE + 32'h123, "R6 page0");

    // Pointer and entry data
    reg_write(4'h4, BASE + 32'h3010);
    reg_read(4'h4, BASE + 32'h3010, "R3 pointer");
    reg_write(4'h8, 32'h8ABC_D000);
    reg_read(4'h8, 32'h8ABC_D000, "R4 entry readback");
    lookup(BASE + 32'h3FFF, "R6 page3");

    // Window boundaries
    reg_write(4'h4, BASE + 32'hF000);
    reg_write(4'h8, 32'hFFFF_F000);
    lookup(BASE + 32'hFFFF, "R8 last byte");
    lookup(BASE + 32'h1_0000, "R8 past end");
    lookup(BASE - 32'h1, "R8 below base");

    // Out-of-window pointer
    reg_write(4'h4, BASE + 32'h1_0000);
    reg_write(4'h8, 32'hFFFF_FFFF);
    reg_read(4'h8, 32'b0, "R5 read outside");
    lookup(BASE + 32'h1, "R5 page0 kept");
    reg_write(4'h4, BASE - 32'h1000);
    reg_write(4'h8, 32'h8000_1000);
    lookup(BASE + 32'hF00A, "R5 page15 kept");

    // Valid bit clear
    reg_write(4'h4, BASE + 32'h3000);
    reg_write(4'h8, 32'h0);
    lookup(BASE + 32'h3004, "R9 unmapped");
    reg_write(4'h4, BASE + 32'h7000);
    reg_write(4'h8, 32'h0001_2000);
    lookup(BASE + 32'h7008, "R9 valid clear");
    reg_read(4'h8, 32'h0001_2000, "R4 invalid entry readback");

    // Write then immediate lookup
    reg_write(4'h4, BASE + 32'h8000);
    reg_write(4'h8, 32'h8123_4000);
    lookup(BASE + 32'h8ABC, "R11 next cycle");

    // Back-pressure burst
    idle();
    bp_on = 1;
    for (int i = 0; i < 24; i++) begin
      logic [31:0] a;
      case (i % 6)
        0: a = BASE + 32'h0010 + 32'(i);
        1: a = BASE + 32'h8000 + 32'(i * 16);
        2: a = BASE + 32'hF000 + 32'(i);
        3: a = BASE + 32'h1_0000 + 32'(i);
        4: a = BASE + 32'h3000 + 32'(i);
        default: a = BASE + 32'h4000;
      endcase
      lookup(a, "R10 burst");
    end
    idle();
    repeat (30) @(posedge clk);
    bp_on = 0;
    repeat (10) @(posedge clk);

    // Disable again
    reg_write(4'h0, 32'h0);
    reg_read(4'h0, 32'h0, "R2 disable readback");
    lookup(BASE + 32'h123, "R7 disabled again");
    idle();
    repeat (10) @(posedge clk);
    chk(sbq.size() == 0, "R10 all results delivered", 32'(sbq.size()), 32'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule